// File: doc/BRIEF.md
# Vector Scatter-Gather Load/Store Sequencer

This block carries out one scatter-gather memory operation on a 128-bit slice of a vector register file. Each lane of an address vector provides a base address. A signed immediate byte offset is added to every base, and each resulting address is used for one 32-bit memory access. The block can also write the new address back into its address lane. Element size is either 32 bits (four independent lanes) or 64 bits. In the 64-bit form a pair of lanes performs two word accesses that share the even lane's base.

A start command supplies the operation: the direction, the element size, the immediate with its add/subtract sense, the writeback flag, a per-byte predicate mask, a per-byte beat-enable mask, the two register indices, and the current data and address vectors. These two masks act separately:
- A lane whose beat is disabled is left completely alone.
- A lane whose predicate is clear makes no memory access, but it still takes part in address writeback. For a load it also has its destination cleared.

Lanes are served in ascending order, with at most one memory request outstanding. A one-cycle done pulse marks the point at which the updated vectors are valid.

Top module: `sg_vec_seq`

## Requirements
- R1: The vector has four 32-bit lanes, with lane e in bits [32e+31:32e] of each vector. Lane e is governed by bit 4e of the predicate mask and bit 4e of the beat mask. Lanes are handled in order 0,1,2,3, and a new memory request is never raised while a load response is pending.
- R2: A lane whose beat bit is 0 makes no memory access. Its data lane and its address lane both keep their input values.
- R3: A load lane whose predicate bit is 0 issues no read, and its data lane becomes zero. If writeback is on, its address lane is still updated.
- R4: A store lane whose predicate bit is 0 issues no write. If writeback is on, its address lane is still updated.
- R5: The byte offset is the 7-bit immediate shifted left by 2 in 32-bit mode or by 3 in 64-bit mode. It is negated when cmd_add is 0. The lane address is the base plus this offset, modulo 2^32.
- R6: In 32-bit mode with writeback on, each processed lane's address lane receives that lane's computed address. With writeback off, addr_out equals addr_in.
- R7: In 64-bit mode, lanes 2k and 2k+1 both take their base from address lane 2k. The even lane accesses A = base + offset, and the odd lane accesses A+4. The low word is at the lower address.
- R8: In 64-bit mode, writeback happens only when the odd lane of a pair is processed. It stores A into address lane 2k and leaves address lane 2k+1 unchanged. If the odd lane's beat is disabled, the pair gets no writeback.
- R9: A load whose cmd_dst_sel equals cmd_adr_sel is refused. reject pulses one cycle after start, and no request is made. busy stays low. A store with equal indices runs normally.
- R10: done is a one-cycle pulse after the last lane, and data_out/addr_out hold the results at that point. A request that is not accepted keeps its valid, address and direction stable.
- R11: A load writes the returned word into its data lane. A store issues mem_req_write=1 with the store data taken from the lane's data_in word. A load issues mem_req_write=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, sampled while idle |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_pair | input | 1 | 1 = 64-bit elements as word pairs |
| cmd_add | input | 1 | 1 = add offset, 0 = subtract |
| cmd_imm | input | 7 | Unsigned immediate before scaling |
| cmd_wb | input | 1 | Write computed addresses back |
| cmd_pred | input | 16 | Per-byte predicate mask |
| cmd_beat | input | 16 | Per-byte beat-enable mask |
| cmd_dst_sel | input | 3 | Data register index |
| cmd_adr_sel | input | 3 | Address register index |
| data_in | input | 128 | Destination/store data vector |
| addr_in | input | 128 | Address vector |
| busy | output | 1 | Operation in progress |
| reject | output | 1 | Illegal load refused (pulse) |
| done | output | 1 | Operation finished (pulse) |
| data_out | output | 128 | Updated data vector |
| addr_out | output | 128 | Updated address vector |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | 32 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |

## Verification
On a load lane, two updates land in the same register update: the returned word is written into the data lane, and the computed address is written back into the address lane. In 64-bit mode the second of these targets a different lane, the even one.

This coincidence is provoked by writeback loads in both element sizes while the memory randomly withholds ready, so the response cycle drifts. It is judged by comparing both output vectors against a lane-by-lane model at done. A writeback that picked the wrong lane, or a data update that was dropped, would show up in one of the two vectors.

// File: rtl/sgv_pkg.sv
package sgv_pkg;
    typedef enum logic [1:0] {
        SG_IDLE = 2'd0,
        SG_RUN  = 2'd1,
        SG_WAIT = 2'd2,
        SG_FIN  = 2'd3
    } sg_state_e;
endpackage

// File: rtl/sgv_offset.sv
module sgv_offset #(
    parameter int WORD_W = 32,
    parameter int IMM_W  = 7
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              pair,
    input  logic              add,
    output logic [WORD_W-1:0] off
);
    logic [WORD_W-1:0] mag;

    always_comb begin
        mag = {{(WORD_W-IMM_W){1'b0}}, imm} << (pair ? 3 : 2);
        off = add ? mag : (WORD_W'(0) - mag);
    end
endmodule

// File: rtl/sgv_lane_addr.sv
module sgv_lane_addr #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    localparam int LIDX  = $clog2(LANES),
    localparam int VEC_W = WORD_W * LANES
) (
    input  logic [VEC_W-1:0]  av,
    input  logic [LIDX-1:0]   lane,
    input  logic              pair,
    input  logic [WORD_W-1:0] off,
    output logic [WORD_W-1:0] addr,
    output logic [LIDX-1:0]   wb_lane,
    output logic [WORD_W-1:0] wb_val,
    output logic              wb_here
);
    localparam int WBYTES = WORD_W / 8;

    logic [WORD_W-1:0] lane_base [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign lane_base[g] = av[g*WORD_W +: WORD_W];
    end

    always_comb begin
        wb_lane = pair ? {lane[LIDX-1:1], 1'b0} : lane;
        addr    = lane_base[wb_lane] + off
                + ((pair && lane[0]) ? WORD_W'(WBYTES) : WORD_W'(0));
        wb_val  = pair ? addr - WORD_W'(WBYTES) : addr;
        wb_here = !pair || lane[0];
    end
endmodule

// File: rtl/sg_vec_seq.sv
module sg_vec_seq #(
    parameter int WORD_W = 32,
    parameter int LANES  = 4,
    parameter int IMM_W  = 7,
    parameter int RIDX_W = 3,
    localparam int VEC_W  = WORD_W * LANES,
    localparam int BYTES  = WORD_W / 8,
    localparam int MASK_W = LANES * BYTES,
    localparam int LIDX   = $clog2(LANES),
    localparam int LSH    = $clog2(WORD_W),
    localparam int VIDX   = LIDX + LSH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmd_store,
    input  logic              cmd_pair,
    input  logic              cmd_add,
    input  logic [IMM_W-1:0]  cmd_imm,
    input  logic              cmd_wb,
    input  logic [MASK_W-1:0] cmd_pred,
    input  logic [MASK_W-1:0] cmd_beat,
    input  logic [RIDX_W-1:0] cmd_dst_sel,
    input  logic [RIDX_W-1:0] cmd_adr_sel,
    input  logic [VEC_W-1:0]  data_in,
    input  logic [VEC_W-1:0]  addr_in,
    output logic              busy,
    output logic              reject,
    output logic              done,
    output logic [VEC_W-1:0]  data_out,
    output logic [VEC_W-1:0]  addr_out,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_rdata
);
    import sgv_pkg::*;

    typedef struct packed {
        sg_state_e         st;
        logic [LIDX-1:0]   lane;
        logic [VEC_W-1:0]  dv;
        logic [VEC_W-1:0]  av;
        logic [MASK_W-1:0] pm;
        logic [MASK_W-1:0] bm;
        logic              store;
        logic              pair;
        logic              wb;
        logic [WORD_W-1:0] off;
        logic              rej;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [WORD_W-1:0] cmd_off;
    logic [WORD_W-1:0] lane_addr;
    logic [LIDX-1:0]   wb_lane;
    logic [WORD_W-1:0] wb_val;
    logic              wb_here;
    logic [VIDX-1:0]   cur_bit;
    logic [VIDX-1:0]   wb_bit;

    sgv_offset #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_offset (
        .imm  (cmd_imm),
        .pair (cmd_pair),
        .add  (cmd_add),
        .off  (cmd_off)
    );

    sgv_lane_addr #(.WORD_W(WORD_W), .LANES(LANES)) u_lane_addr (
        .av      (seq_q.av),
        .lane    (seq_q.lane),
        .pair    (seq_q.pair),
        .off     (seq_q.off),
        .addr    (lane_addr),
        .wb_lane (wb_lane),
        .wb_val  (wb_val),
        .wb_here (wb_here)
    );

    assign cur_bit = {seq_q.lane, {LSH{1'b0}}};
    assign wb_bit  = {wb_lane, {LSH{1'b0}}};

    always_comb begin
        logic adv;
        logic do_wb;
        seq_d = seq_q;
        seq_d.rej = 1'b0;
        adv   = 1'b0;
        do_wb = 1'b0;
        unique case (seq_q.st)
            SG_IDLE: begin
                if (start) begin
                    if (!cmd_store && (cmd_dst_sel == cmd_adr_sel)) begin
                        seq_d.rej = 1'b1;
                    end else begin
                        seq_d.st    = SG_RUN;
                        seq_d.lane  = '0;
                        seq_d.dv    = data_in;
                        seq_d.av    = addr_in;
                        seq_d.pm    = cmd_pred;
                        seq_d.bm    = cmd_beat;
                        seq_d.store = cmd_store;
                        seq_d.pair  = cmd_pair;
                        seq_d.wb    = cmd_wb;
                        seq_d.off   = cmd_off;
                    end
                end
            end
            SG_RUN: begin
                if (!seq_q.bm[0]) begin
                    adv = 1'b1;
                end else if (!seq_q.pm[0]) begin
                    if (!seq_q.store) begin
                        seq_d.dv[cur_bit +: WORD_W] = '0;
                    end
                    do_wb = 1'b1;
                    adv   = 1'b1;
                end else if (mem_req_ready) begin
                    if (seq_q.store) begin
                        do_wb = 1'b1;
                        adv   = 1'b1;
                    end else begin
                        seq_d.st = SG_WAIT;
                    end
                end
            end
            SG_WAIT: begin
                if (mem_rsp_valid) begin
                    seq_d.dv[cur_bit +: WORD_W] = mem_rsp_rdata;
                    do_wb = 1'b1;
                    adv   = 1'b1;
                end
            end
            default: begin
                seq_d.st = SG_IDLE;
            end
        endcase
        if (do_wb && seq_q.wb && wb_here) begin
            seq_d.av[wb_bit +: WORD_W] = wb_val;
        end
        if (adv) begin
            seq_d.pm = seq_q.pm >> BYTES;
            seq_d.bm = seq_q.bm >> BYTES;
            if (seq_q.lane == LIDX'(LANES-1)) begin
                seq_d.st = SG_FIN;
            end else begin
                seq_d.lane = seq_q.lane + LIDX'(1);
                seq_d.st   = SG_RUN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy          = (seq_q.st != SG_IDLE);
    assign done          = (seq_q.st == SG_FIN);
    assign reject        = seq_q.rej;
    assign data_out      = seq_q.dv;
    assign addr_out      = seq_q.av;
    assign mem_req_valid = (seq_q.st == SG_RUN) && seq_q.bm[0] && seq_q.pm[0];
    assign mem_req_write = seq_q.store;
    assign mem_req_addr  = lane_addr;
    assign mem_req_wdata = seq_q.dv[cur_bit +: WORD_W];
endmodule

// File: rtl/sgv_checker.sv
module sgv_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              reject,
    input logic              done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [WORD_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid); // R9
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> !busy && !done); // R9
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid); // R1
endmodule

bind sg_vec_seq sgv_checker #(.WORD_W(WORD_W)) u_sgv_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .reject        (reject),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/test_sg_vec_seq.sv
`timescale 1ns/1ps
module test_sg_vec_seq;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmd_store = 1'b0, cmd_pair = 1'b0, cmd_add = 1'b1, cmd_wb = 1'b0;
    logic [6:0]   cmd_imm = '0;
    logic [15:0]  cmd_pred = '0, cmd_beat = '0;
    logic [2:0]   cmd_dst_sel = '0, cmd_adr_sel = '0;
    logic [127:0] data_in = '0, addr_in = '0;
    logic         busy, reject, done;
    logic [127:0] data_out, addr_out;
    logic         mem_req_valid, mem_req_write;
    logic         mem_req_ready = 1'b0;
    logic [31:0]  mem_req_addr, mem_req_wdata;
    logic         mem_rsp_valid = 1'b0;
    logic [31:0]  mem_rsp_rdata = '0;

    int total = 0;
    int bad = 0;
    int n_acc = 0;
    int cycles = 0;
    logic        stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] log_a [128];
    logic        log_w [128];
    logic [31:0] log_d [128];

    always #2.5 clk = ~clk;

    sg_vec_seq i_sg_vec_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_store(cmd_store),
        .cmd_pair(cmd_pair), .cmd_add(cmd_add), .cmd_imm(cmd_imm), .cmd_wb(cmd_wb),
        .cmd_pred(cmd_pred), .cmd_beat(cmd_beat), .cmd_dst_sel(cmd_dst_sel),
        .cmd_adr_sel(cmd_adr_sel), .data_in(data_in), .addr_in(addr_in),
        .busy(busy), .reject(reject), .done(done), .data_out(data_out),
        .addr_out(addr_out), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h3C5A_96E1;
    endfunction

    // memory model: logs accepted requests, answers reads one cycle later
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready <= !stall_en || lfsr[0];
        mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
        mem_rsp_rdata <= memval(mem_req_addr);
        if (mem_req_valid && mem_req_ready) begin
            log_a[n_acc] <= mem_req_addr;
            log_w[n_acc] <= mem_req_write;
            log_d[n_acc] <= mem_req_wdata;
            n_acc <= n_acc + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog expired act=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic st, input logic dw, input logic ad, input logic [6:0] imm,
                          input logic wbf, input logic [15:0] pm, input logic [15:0] bm,
                          input logic [127:0] dv, input logic [127:0] av,
                          input logic [2:0] di, input logic [2:0] ai, input string tag);
        logic [31:0]  off;
        logic [127:0] edv, eav;
        logic [31:0]  ea [4];
        logic [31:0]  ed [4];
        logic [31:0]  a;
        int ne, b, acc0, wait_n;
        off = {25'b0, imm} << (dw ? 3 : 2);
        if (!ad) off = 32'd0 - off;
        edv = dv; eav = av; ne = 0;
        for (int e = 0; e < 4; e++) begin
            if (bm[4*e]) begin
                b = dw ? (e & ~1) : e;
                a = av[32*b +: 32] + off + ((dw && (e % 2 == 1)) ? 32'd4 : 32'd0);
                if (pm[4*e]) begin
                    ea[ne] = a; ed[ne] = dv[32*e +: 32]; ne++;
                end
                if (!st) edv[32*e +: 32] = pm[4*e] ? memval(a) : 32'd0;
                if (wbf) begin
                    if (!dw) eav[32*e +: 32] = a;
                    else if (e % 2 == 1) eav[32*b +: 32] = a - 32'd4;
                end
            end
        end
        @(negedge clk);
        acc0 = n_acc;
        cmd_store = st; cmd_pair = dw; cmd_add = ad; cmd_imm = imm; cmd_wb = wbf;
        cmd_pred = pm; cmd_beat = bm; data_in = dv; addr_in = av;
        cmd_dst_sel = di; cmd_adr_sel = ai; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 300) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done, {tag, " R10 done pulse"}, 128'(done), 128'd1);
        chk(data_out == edv, {tag, " R11 data vector"}, data_out, edv);
        chk(addr_out == eav, {tag, " R6 address vector"}, addr_out, eav);
        chk(n_acc - acc0 == ne, {tag, " R1 access count"}, 128'(n_acc - acc0), 128'(ne));
        for (int k = 0; k < ne && k < n_acc - acc0; k++) begin
            chk(log_a[acc0+k] == ea[k], {tag, " R5 access address in R1 order"}, 128'(log_a[acc0+k]), 128'(ea[k]));
            chk(log_w[acc0+k] == st, {tag, " R11 write flag"}, 128'(log_w[acc0+k]), 128'(st));
            if (st) chk(log_d[acc0+k] == ed[k], {tag, " R11 store data"}, 128'(log_d[acc0+k]), 128'(ed[k]));
        end
        @(negedge clk);
        chk(!done, {tag, " R10 done one cycle"}, 128'(done), 128'd0);
    endtask

    localparam logic [127:0] AV0 = {32'h0000_4300, 32'h0000_2200, 32'h0000_1100, 32'h0000_0400};
    localparam logic [127:0] DV0 = {32'hDDDD_0003, 32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};

    task automatic t_reset();
        chk(!busy && !done && !reject && !mem_req_valid, "R10 reset idle",
            {busy, done, reject, mem_req_valid}, 128'd0);
    endtask

    task automatic t_load32_plain();
        run_op(0, 0, 1, 7'd5, 0, 16'hFFFF, 16'hFFFF, DV0, AV0, 3'd1, 3'd2, "load32");
        chk(data_out[63:32] == memval(32'h0000_1114), "R11 lane1 load word", data_out[63:32], memval(32'h0000_1114));
    endtask

    task automatic t_load32_masks();
        // lane1 predicate off (bit 4), lane3 beat off (bit 12), subtract 12
        run_op(0, 0, 0, 7'd3, 1, 16'hFFEF, 16'h0FFF, DV0, AV0, 3'd1, 3'd2, "load32 masks");
        chk(data_out[63:32] == 32'd0, "R3 predicated load lane zero", data_out[63:32], 0);
        chk(addr_out[63:32] == 32'h0000_10F4, "R3 predicated lane writeback", addr_out[63:32], 32'h0000_10F4);
        chk(data_out[127:96] == DV0[127:96], "R2 skipped data lane kept", data_out[127:96], DV0[127:96]);
        chk(addr_out[127:96] == AV0[127:96], "R2 skipped address lane kept", addr_out[127:96], AV0[127:96]);
    endtask

    task automatic t_store32();
        int n0;
        n0 = n_acc;
        run_op(1, 0, 1, 7'd1, 1, 16'hF0FF, 16'hFFFF, DV0, AV0, 3'd4, 3'd5, "store32");
        chk(n_acc - n0 == 3, "R4 predicated store not written", 128'(n_acc - n0), 3);
        chk(addr_out[95:64] == 32'h0000_2204, "R4 predicated store writeback", addr_out[95:64], 32'h0000_2204);
    endtask

    task automatic t_nowb();
        stall_en = 1'b1;
        run_op(1, 0, 1, 7'd9, 0, 16'hFFFF, 16'hFFFF, DV0, AV0, 3'd0, 3'd1, "store32 nowb");
        chk(addr_out == AV0, "R6 no writeback keeps addresses", addr_out, AV0);
        stall_en = 1'b0;
    endtask

    task automatic t_load64();
        stall_en = 1'b1;
        run_op(0, 1, 1, 7'd2, 1, 16'hFFFF, 16'hFFFF, DV0, AV0, 3'd6, 3'd0, "load64");
        chk(data_out[63:32] == memval(32'h0000_0414), "R7 odd lane at base+4", data_out[63:32], memval(32'h0000_0414));
        chk(addr_out[31:0] == 32'h0000_0410, "R8 even lane gets pair address", addr_out[31:0], 32'h0000_0410);
        chk(addr_out[63:32] == AV0[63:32], "R8 odd address lane kept", addr_out[63:32], AV0[63:32]);
        stall_en = 1'b0;
    endtask

    task automatic t_store64_beat();
        int n0;
        n0 = n_acc;
        // lane1 beat off (bit 4): pair 0 gets no writeback
        run_op(1, 1, 0, 7'd1, 1, 16'hFFFF, 16'hFFEF, DV0, AV0, 3'd2, 3'd3, "store64 beat");
        chk(n_acc - n0 == 3, "R2 skipped lane no access", 128'(n_acc - n0), 3);
        chk(addr_out[31:0] == AV0[31:0], "R8 no writeback without odd lane", addr_out[31:0], AV0[31:0]);
        chk(addr_out[95:64] == 32'h0000_21F8, "R8 pair1 writeback", addr_out[95:64], 32'h0000_21F8);
    endtask

    task automatic t_wrap();
        logic [127:0] av;
        av = {32'd8, 32'd8, 32'd8, 32'h0000_0004};
        run_op(0, 0, 0, 7'd3, 1, 16'h0001, 16'h0001, DV0, av, 3'd1, 3'd2, "wrap");
        chk(addr_out[31:0] == 32'hFFFF_FFF8, "R5 modulo wrap", addr_out[31:0], 32'hFFFF_FFF8);
    endtask

    task automatic t_reject();
        int n0;
        n0 = n_acc;
        @(negedge clk);
        cmd_store = 1'b0; cmd_dst_sel = 3'd3; cmd_adr_sel = 3'd3; cmd_beat = 16'hFFFF;
        cmd_pred = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(reject && !busy, "R9 illegal load refused", {reject, busy}, 128'b10);
        @(negedge clk);
        chk(!reject && !busy && n_acc == n0, "R9 no activity after refusal", {reject, busy}, 0);
        run_op(1, 0, 1, 7'd0, 0, 16'hFFFF, 16'hFFFF, DV0, AV0, 3'd3, 3'd3, "R9 store equal indices");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_load32_plain();
        t_load32_masks();
        t_store32();
        t_nowb();
        t_load64();
        t_store64_beat();
        t_wrap();
        t_reject();
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule